// File: doc/BRIEF.md
# Instruction Fetch Line Request Unit

This unit sits between a multithreaded fetch stage and the instruction cache. Each thread owns a single buffered cache line, tagged with the block-aligned address it holds and a valid bit. When the fetch stage presents a thread and a program counter, the unit clears the offset bits of the address and compares the result with that thread's tag. On a match the line is handed back in the same cycle. On a miss the unit sends a whole-line read to the cache, and the read carries a per-thread sequence tag so that the response can be matched to it later.

The cache may refuse a read. A refused read is parked in one retry slot that all threads share, and a global blocked flag then stops every thread from starting a new line fetch. When the cache signals retry, the parked read is sent again. Squashing a thread bumps its sequence tag, so any response still in flight for that thread is dropped when it arrives. If that thread owns the retry slot, the slot is emptied. Fetches are also withheld while an interrupt is pending and the low two address bits are zero. A translation fault flag stops a miss from reaching the cache.

Top module: `ifetch_line_unit`

## Requirements
- R1: A line read carries the fetch address with its low log2(LINE_BYTES) bits cleared, the requesting thread id, and that thread's new sequence tag.
- R2: If the thread's line is valid and its tag equals the aligned address, fetch_ok_o rises in the same cycle and fetch_line_o shows that line. No read is issued. A thread in state DONE (5) returns to RUN (0) after such a hit.
- R3: On a miss the read is issued in the same cycle and the thread's line becomes invalid. If mem_req_ready_i is high, the thread is in WAIT_RSP (3) on the next cycle.
- R4: If mem_req_ready_i is low for a new read, the read is kept in the shared retry slot. cache_blocked_o is 1 from the next cycle, and the thread enters WAIT_RETRY (4).
- R5: While cache_blocked_o is 1, no thread starts a new read and no fetch_ok_o is given.
- R6: mem_retry_i with an occupied slot resends the same address, thread and tag. If the resend is accepted, cache_blocked_o clears and the owner enters WAIT_RSP on the next cycle. If it is refused, both stay as they are.
- R7: mem_retry_i with an empty slot issues no read and only clears cache_blocked_o on the next cycle.
- R8: A response is taken only if its thread is in WAIT_RSP and its tag equals that thread's outstanding tag. A taken response writes the line and marks it valid, and the thread enters BLOCKED (2) if stall_i is high for it, or DONE (5) otherwise. Any other response pulses rsp_drop_o in the same cycle.
- R9: squash_i for a thread puts it in SQUASH (1) on the next cycle and makes its outstanding response stale. It also empties the retry slot if that thread owns it, but cache_blocked_o stays set.
- R10: While irq_pending_i is high and fetch_pc_i[1:0] is 00, no read is issued and no hit is reported.
- R11: A miss with xlate_fault_i high issues no read and leaves the thread state unchanged.
- R12: After reset every thread is in RUN (0). A thread may fetch only from RUN or DONE, with no stall and no squash. BLOCKED and SQUASH return to RUN one cycle after the stall or squash is gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Fetch attempt this cycle |
| fetch_tid_i | input | TID_W | Thread of the fetch attempt |
| fetch_pc_i | input | ADDR_W | Fetch program counter |
| xlate_fault_i | input | 1 | Address translation fault for this attempt |
| irq_pending_i | input | 1 | Interrupt pending |
| fetch_ok_o | output | 1 | Buffered line hit, line available now |
| fetch_line_o | output | LINE_W | Buffered line of the fetching thread |
| mem_req_valid_o | output | 1 | Line read request to the cache |
| mem_req_addr_o | output | ADDR_W | Aligned line address |
| mem_req_tid_o | output | TID_W | Requesting thread |
| mem_req_tag_o | output | SEQ_W | Sequence tag of the read |
| mem_req_ready_i | input | 1 | Cache accepts the read this cycle |
| mem_retry_i | input | 1 | Cache can take a refused read again |
| mem_rsp_valid_i | input | 1 | Line response valid |
| mem_rsp_tid_i | input | TID_W | Response thread |
| mem_rsp_tag_i | input | SEQ_W | Response sequence tag |
| mem_rsp_data_i | input | LINE_W | Response line data |
| rsp_drop_o | output | 1 | Response discarded as stale |
| squash_i | input | NUM_THREADS | Per-thread squash |
| stall_i | input | NUM_THREADS | Per-thread downstream stall |
| cache_blocked_o | output | 1 | Shared retry blocking active |
| thr_state_o | output | NUM_THREADS*3 | Per-thread state codes |

## Verification
The bench first sends a response whose tag is one ahead of the outstanding one. A design that matched on thread alone would take it, and the line and state would come out wrong. It then squashes a thread with a read in flight and delivers the old tag; a design that did not invalidate the tag would fill the buffer with stale data. A thread that owns the parked read is squashed and then a retry arrives. Here a wrong design would either resend for a dead thread or leave every thread blocked for good. A retry that is refused, a stall that lands during the wait for a response, and the interrupt filter on the low address bits show whether requests are lost, duplicated or let through.

// File: rtl/ifl_pkg.sv
package ifl_pkg;
  typedef enum logic [2:0] {
    TS_RUN        = 3'd0,
    TS_SQUASH     = 3'd1,
    TS_BLOCKED    = 3'd2,
    TS_WAIT_RSP   = 3'd3,
    TS_WAIT_RETRY = 3'd4,
    TS_DONE       = 3'd5
  } thr_state_e;
endpackage

// File: rtl/ifl_thread.sv
module ifl_thread
  import ifl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128,
  parameter int SEQ_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              squash_i,
  input  logic              stall_i,
  input  logic              miss_fire_i,
  input  logic              miss_accept_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic              retry_done_i,
  input  logic              fetch_ok_i,
  input  logic              rsp_valid_i,
  input  logic [SEQ_W-1:0]  rsp_tag_i,
  input  logic [LINE_W-1:0] rsp_data_i,
  output thr_state_e        state_o,
  output logic [SEQ_W-1:0]  next_tag_o,
  output logic [ADDR_W-1:0] line_tag_o,
  output logic              line_valid_o,
  output logic [LINE_W-1:0] line_data_o,
  output logic              rsp_take_o
);
  thr_state_e        st_q, st_d;
  logic [SEQ_W-1:0]  seq_q;

  assign next_tag_o = seq_q + SEQ_W'(1);
  assign rsp_take_o = rsp_valid_i && (st_q == TS_WAIT_RSP) && (rsp_tag_i == seq_q) && !squash_i;
  assign state_o    = st_q;

  always_comb begin
    st_d = st_q;
    if (squash_i)                st_d = TS_SQUASH;
    else if (rsp_take_o)         st_d = stall_i ? TS_BLOCKED : TS_DONE;
    else if (miss_fire_i)        st_d = miss_accept_i ? TS_WAIT_RSP : TS_WAIT_RETRY;
    else if (retry_done_i)       st_d = TS_WAIT_RSP;
    else if (stall_i && st_q != TS_WAIT_RSP && st_q != TS_WAIT_RETRY)
                                 st_d = TS_BLOCKED;
    else if (st_q == TS_BLOCKED || st_q == TS_SQUASH)
                                 st_d = TS_RUN;
    else if (fetch_ok_i)         st_d = TS_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= TS_RUN;
      seq_q        <= '0;
      line_tag_o   <= '0;
      line_valid_o <= 1'b0;
      line_data_o  <= '0;
    end else begin
      st_q <= st_d;
      // a squash or a new read retires the outstanding tag
      if (squash_i || miss_fire_i) seq_q <= seq_q + SEQ_W'(1);
      if (miss_fire_i) begin
        line_tag_o   <= miss_addr_i;
        line_valid_o <= 1'b0;
      end else if (rsp_take_o) begin
        line_data_o  <= rsp_data_i;
        line_valid_o <= 1'b1;
      end
    end
  end

  // R8
  rsp_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_take_o |=> line_valid_o && (state_o == TS_BLOCKED || state_o == TS_DONE));
  // R9
  squash_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> state_o == TS_SQUASH);
  // R3
  miss_inval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_fire_i |=> !line_valid_o && line_tag_o == $past(miss_addr_i));
endmodule

// File: rtl/ifl_retry_slot.sv
module ifl_retry_slot #(
  parameter int ADDR_W      = 32,
  parameter int TID_W       = 1,
  parameter int SEQ_W       = 3,
  parameter int NUM_THREADS = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   capture_i,
  input  logic [ADDR_W-1:0]      cap_addr_i,
  input  logic [TID_W-1:0]       cap_tid_i,
  input  logic [SEQ_W-1:0]       cap_tag_i,
  input  logic                   retry_i,
  input  logic                   accept_i,
  input  logic [NUM_THREADS-1:0] squash_i,
  output logic                   blocked_o,
  output logic                   fire_o,
  output logic [ADDR_W-1:0]      slot_addr_o,
  output logic [TID_W-1:0]       slot_tid_o,
  output logic [SEQ_W-1:0]       slot_tag_o
);
  logic valid_q;
  logic live;

  assign live   = valid_q && !squash_i[slot_tid_o];
  assign fire_o = retry_i && blocked_o && live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q     <= 1'b0;
      blocked_o   <= 1'b0;
      slot_addr_o <= '0;
      slot_tid_o  <= '0;
      slot_tag_o  <= '0;
    end else if (capture_i) begin
      valid_q     <= 1'b1;
      blocked_o   <= 1'b1;
      slot_addr_o <= cap_addr_i;
      slot_tid_o  <= cap_tid_i;
      slot_tag_o  <= cap_tag_i;
    end else begin
      if (valid_q && squash_i[slot_tid_o]) valid_q <= 1'b0;
      // empty slot: a retry only lifts the block
      if (retry_i && blocked_o && (!live || accept_i)) begin
        blocked_o <= 1'b0;
        valid_q   <= 1'b0;
      end
    end
  end

  // R4
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> blocked_o && valid_q);
  // R7
  empty_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_i && blocked_o && !valid_q |=> !blocked_o);
  // R6
  resend_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o && accept_i |=> !blocked_o && !valid_q);
endmodule

// File: rtl/ifetch_line_unit.sv
module ifetch_line_unit
  import ifl_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 16,
  parameter int SEQ_W       = 3,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int LINE_W     = LINE_BYTES * 8,
  localparam int ST_W       = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      fetch_valid_i,
  input  logic [TID_W-1:0]          fetch_tid_i,
  input  logic [ADDR_W-1:0]         fetch_pc_i,
  input  logic                      xlate_fault_i,
  input  logic                      irq_pending_i,
  output logic                      fetch_ok_o,
  output logic [LINE_W-1:0]         fetch_line_o,
  output logic                      mem_req_valid_o,
  output logic [ADDR_W-1:0]         mem_req_addr_o,
  output logic [TID_W-1:0]          mem_req_tid_o,
  output logic [SEQ_W-1:0]          mem_req_tag_o,
  input  logic                      mem_req_ready_i,
  input  logic                      mem_retry_i,
  input  logic                      mem_rsp_valid_i,
  input  logic [TID_W-1:0]          mem_rsp_tid_i,
  input  logic [SEQ_W-1:0]          mem_rsp_tag_i,
  input  logic [LINE_W-1:0]         mem_rsp_data_i,
  output logic                      rsp_drop_o,
  input  logic [NUM_THREADS-1:0]    squash_i,
  input  logic [NUM_THREADS-1:0]    stall_i,
  output logic                      cache_blocked_o,
  output logic [NUM_THREADS*ST_W-1:0] thr_state_o
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_BYTES - 1);

  thr_state_e        st       [NUM_THREADS];
  logic [SEQ_W-1:0]  ntag     [NUM_THREADS];
  logic [ADDR_W-1:0] ltag     [NUM_THREADS];
  logic              lvalid   [NUM_THREADS];
  logic [LINE_W-1:0] ldata    [NUM_THREADS];
  logic [NUM_THREADS-1:0] rsp_take;

  logic [ADDR_W-1:0] aligned;
  logic              gate, thr_ready, hit, miss_fire;
  logic              slot_fire;
  logic [ADDR_W-1:0] slot_addr;
  logic [TID_W-1:0]  slot_tid;
  logic [SEQ_W-1:0]  slot_tag;

  assign aligned   = fetch_pc_i & ~OFF_MASK;
  assign gate      = cache_blocked_o || (irq_pending_i && fetch_pc_i[1:0] == 2'b00);
  assign thr_ready = (st[fetch_tid_i] == TS_RUN || st[fetch_tid_i] == TS_DONE)
                     && !stall_i[fetch_tid_i] && !squash_i[fetch_tid_i];
  assign hit       = lvalid[fetch_tid_i] && (ltag[fetch_tid_i] == aligned);
  assign fetch_ok_o   = fetch_valid_i && !gate && thr_ready && hit;
  assign miss_fire    = fetch_valid_i && !gate && thr_ready && !hit && !xlate_fault_i;
  assign fetch_line_o = ldata[fetch_tid_i];

  assign mem_req_valid_o = miss_fire || slot_fire;
  assign mem_req_addr_o  = slot_fire ? slot_addr : aligned;
  assign mem_req_tid_o   = slot_fire ? slot_tid  : fetch_tid_i;
  assign mem_req_tag_o   = slot_fire ? slot_tag  : ntag[fetch_tid_i];
  assign rsp_drop_o      = mem_rsp_valid_i && (rsp_take == '0);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    ifl_thread #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .SEQ_W(SEQ_W)) u_thr (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .squash_i     (squash_i[t]),
      .stall_i      (stall_i[t]),
      .miss_fire_i  (miss_fire && fetch_tid_i == TID_W'(t)),
      .miss_accept_i(mem_req_ready_i),
      .miss_addr_i  (aligned),
      .retry_done_i (slot_fire && mem_req_ready_i && slot_tid == TID_W'(t)),
      .fetch_ok_i   (fetch_ok_o && fetch_tid_i == TID_W'(t)),
      .rsp_valid_i  (mem_rsp_valid_i && mem_rsp_tid_i == TID_W'(t)),
      .rsp_tag_i    (mem_rsp_tag_i),
      .rsp_data_i   (mem_rsp_data_i),
      .state_o      (st[t]),
      .next_tag_o   (ntag[t]),
      .line_tag_o   (ltag[t]),
      .line_valid_o (lvalid[t]),
      .line_data_o  (ldata[t]),
      .rsp_take_o   (rsp_take[t])
    );
    assign thr_state_o[t*ST_W +: ST_W] = st[t];
  end

  ifl_retry_slot #(.ADDR_W(ADDR_W), .TID_W(TID_W), .SEQ_W(SEQ_W), .NUM_THREADS(NUM_THREADS)) u_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (miss_fire && !mem_req_ready_i),
    .cap_addr_i (aligned),
    .cap_tid_i  (fetch_tid_i),
    .cap_tag_i  (ntag[fetch_tid_i]),
    .retry_i    (mem_retry_i),
    .accept_i   (mem_req_ready_i),
    .squash_i   (squash_i),
    .blocked_o  (cache_blocked_o),
    .fire_o     (slot_fire),
    .slot_addr_o(slot_addr),
    .slot_tid_o (slot_tid),
    .slot_tag_o (slot_tag)
  );

  // R5
  blocked_no_new_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_blocked_o && mem_req_valid_o |-> mem_retry_i);
  // R2
  hit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_ok_o |-> !mem_req_valid_o);
endmodule

// File: tb/ifetch_line_unit_bench.sv
module ifetch_line_unit_bench;
  localparam int NT = 2, AW = 32, LB = 16, SW = 3, LW = LB * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          fetch_valid, xlate_fault, irq_pending;
  logic [0:0]    fetch_tid;
  logic [AW-1:0] fetch_pc;
  logic          fetch_ok_o;
  logic [LW-1:0] fetch_line_o;
  logic          mem_req_valid_o;
  logic [AW-1:0] mem_req_addr_o;
  logic [0:0]    mem_req_tid_o;
  logic [SW-1:0] mem_req_tag_o;
  logic          mem_ready, mem_retry, rsp_valid;
  logic [0:0]    rsp_tid;
  logic [SW-1:0] rsp_tag;
  logic [LW-1:0] rsp_data;
  logic          rsp_drop_o;
  logic [NT-1:0] squash, stall;
  logic          cache_blocked_o;
  logic [NT*3-1:0] thr_state_o;

  ifetch_line_unit #(.NUM_THREADS(NT), .ADDR_W(AW), .LINE_BYTES(LB), .SEQ_W(SW)) u_ifetch_line_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_valid_i(fetch_valid), .fetch_tid_i(fetch_tid), .fetch_pc_i(fetch_pc),
    .xlate_fault_i(xlate_fault), .irq_pending_i(irq_pending),
    .fetch_ok_o(fetch_ok_o), .fetch_line_o(fetch_line_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_tid_o(mem_req_tid_o), .mem_req_tag_o(mem_req_tag_o),
    .mem_req_ready_i(mem_ready), .mem_retry_i(mem_retry),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_tid_i(rsp_tid), .mem_rsp_tag_i(rsp_tag),
    .mem_rsp_data_i(rsp_data), .rsp_drop_o(rsp_drop_o),
    .squash_i(squash), .stall_i(stall),
    .cache_blocked_o(cache_blocked_o), .thr_state_o(thr_state_o)
  );

  typedef struct packed { logic [AW-1:0] addr; logic tid; } req_t;
  req_t exp_q[$];
  logic [SW-1:0] last_tag [NT];
  int checks = 0, fails = 0;
  bit done = 1'b0;
  localparam logic [LW-1:0] D0 = {4{32'hA5C3_0F11}};
  localparam logic [LW-1:0] D1 = {4{32'h5A3C_F0EE}};

  task automatic chk(input bit ok, input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] st(input int t);
    return thr_state_o[t*3 +: 3];
  endfunction

  task automatic clr();
    fetch_valid = 0; fetch_tid = 0; fetch_pc = '0; xlate_fault = 0; irq_pending = 0;
    mem_ready = 1; mem_retry = 0; rsp_valid = 0; rsp_tid = 0; rsp_tag = '0; rsp_data = '0;
    squash = '0; stall = '0;
  endtask

  task automatic adv();
    @(posedge clk); #2; clr();
  endtask

  task automatic do_fetch(input logic tid, input logic [AW-1:0] pc);
    fetch_valid = 1; fetch_tid = tid; fetch_pc = pc;
  endtask

  task automatic expect_req(input logic [AW-1:0] a, input logic tid);
    req_t r;
    r.addr = a; r.tid = tid;
    exp_q.push_back(r);
  endtask

  // scoreboard monitor: every request on the cache port must match the queue head
  always @(negedge clk) begin
    req_t got, e;
    if (rst_n && mem_req_valid_o) begin
      got.addr = mem_req_addr_o; got.tid = mem_req_tid_o[0];
      last_tag[mem_req_tid_o] = mem_req_tag_o;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected request actual=%0h expected=none", got);
      end else begin
        e = exp_q.pop_front();
        if (e !== got) begin
          fails++;
          $display("FAIL R1 request actual=%0h expected=%0h", got, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] tag8, t1tag;
    clr();
    repeat (2) @(posedge clk);
    @(negedge clk);
    for (int t = 0; t < NT; t++) chk(st(t) == 3'd0, "R12 reset state", LW'(st(t)), 0);
    chk(cache_blocked_o == 0, "R4 reset blocked", LW'(cache_blocked_o), 0);
    @(posedge clk); #2; rst_n = 1;

    // S1 miss T0
    do_fetch(0, 32'h1234); expect_req(32'h1230, 0);
    @(negedge clk); chk(fetch_ok_o == 0, "R3 miss no hit", LW'(fetch_ok_o), 0);
    // S2 thread waiting -> not ready
    adv(); do_fetch(0, 32'h1234);
    @(negedge clk);
    chk(st(0) == 3'd3, "R3 wait rsp", LW'(st(0)), 3);
    chk(mem_req_valid_o == 0, "R12 no fetch while waiting", LW'(mem_req_valid_o), 0);
    // S3 wrong tag
    adv(); rsp_valid = 1; rsp_tid = 0; rsp_tag = last_tag[0] + 1'b1; rsp_data = D1;
    @(negedge clk); chk(rsp_drop_o == 1, "R8 wrong tag dropped", LW'(rsp_drop_o), 1);
    // S4 good response
    adv(); rsp_valid = 1; rsp_tid = 0; rsp_tag = last_tag[0]; rsp_data = D0;
    @(negedge clk);
    chk(rsp_drop_o == 0, "R8 good rsp taken", LW'(rsp_drop_o), 0);
    chk(st(0) == 3'd3, "R8 still waiting before fill", LW'(st(0)), 3);
    // S5 hit
    adv(); do_fetch(0, 32'h123C);
    @(negedge clk);
    chk(st(0) == 3'd5, "R8 done state", LW'(st(0)), 5);
    chk(fetch_ok_o == 1, "R2 hit", LW'(fetch_ok_o), 1);
    chk(fetch_line_o == D0, "R2 line data", fetch_line_o, D0);
    chk(mem_req_valid_o == 0, "R2 no request on hit", LW'(mem_req_valid_o), 0);
    // S6 fault
    adv(); do_fetch(0, 32'h1240); xlate_fault = 1;
    @(negedge clk);
    chk(st(0) == 3'd0, "R2 hit returns to run", LW'(st(0)), 0);
    chk(mem_req_valid_o == 0, "R11 fault no request", LW'(mem_req_valid_o), 0);
    // S7 irq withheld
    adv(); do_fetch(0, 32'h1240); irq_pending = 1;
    @(negedge clk);
    chk(st(0) == 3'd0, "R11 state unchanged", LW'(st(0)), 0);
    chk(mem_req_valid_o == 0, "R10 irq withholds", LW'(mem_req_valid_o), 0);
    // S8 irq but low bits nonzero, refused
    adv(); do_fetch(0, 32'h1242); irq_pending = 1; mem_ready = 0; expect_req(32'h1240, 0);
    @(negedge clk); chk(mem_req_valid_o == 1, "R10 low bits nonzero pass", LW'(mem_req_valid_o), 1);
    // S9 blocked
    adv(); do_fetch(1, 32'h2000); tag8 = last_tag[0];
    @(negedge clk);
    chk(cache_blocked_o == 1, "R4 blocked", LW'(cache_blocked_o), 1);
    chk(st(0) == 3'd4, "R4 wait retry", LW'(st(0)), 4);
    chk(mem_req_valid_o == 0, "R5 no new fetch", LW'(mem_req_valid_o), 0);
    // S10 retry refused
    adv(); mem_retry = 1; mem_ready = 0; expect_req(32'h1240, 0);
    @(negedge clk); chk(mem_req_tag_o == tag8, "R6 resend tag", LW'(mem_req_tag_o), LW'(tag8));
    // S11 retry accepted
    adv(); mem_retry = 1; mem_ready = 1; expect_req(32'h1240, 0);
    @(negedge clk);
    chk(cache_blocked_o == 1, "R6 refused stays blocked", LW'(cache_blocked_o), 1);
    chk(st(0) == 3'd4, "R6 refused stays waiting", LW'(st(0)), 4);
    // S12 stall while waiting
    adv(); stall[0] = 1;
    @(negedge clk);
    chk(cache_blocked_o == 0, "R6 block cleared", LW'(cache_blocked_o), 0);
    chk(st(0) == 3'd3, "R6 wait rsp after resend", LW'(st(0)), 3);
    // S13 response under stall
    adv(); stall[0] = 1; rsp_valid = 1; rsp_tid = 0; rsp_tag = tag8; rsp_data = D1;
    @(negedge clk); chk(rsp_drop_o == 0, "R8 resent rsp taken", LW'(rsp_drop_o), 0);
    adv();
    @(negedge clk); chk(st(0) == 3'd2, "R8 blocked on stall", LW'(st(0)), 2);
    adv();
    @(negedge clk); chk(st(0) == 3'd0, "R12 blocked to run", LW'(st(0)), 0);
    adv(); do_fetch(0, 32'h1248);
    @(negedge clk);
    chk(fetch_ok_o == 1, "R2 hit new line", LW'(fetch_ok_o), 1);
    chk(fetch_line_o == D1, "R2 new line data", fetch_line_o, D1);
    // squash with outstanding read
    adv(); do_fetch(1, 32'h2000); expect_req(32'h2000, 1);
    @(negedge clk);
    adv(); squash[1] = 1;
    @(negedge clk); chk(st(1) == 3'd3, "R3 T1 wait rsp", LW'(st(1)), 3);
    adv(); t1tag = last_tag[1]; rsp_valid = 1; rsp_tid = 1; rsp_tag = t1tag; rsp_data = D0;
    @(negedge clk);
    chk(st(1) == 3'd1, "R9 squash state", LW'(st(1)), 1);
    chk(rsp_drop_o == 1, "R9 stale rsp dropped", LW'(rsp_drop_o), 1);
    adv();
    @(negedge clk); chk(st(1) == 3'd0, "R12 squash to run", LW'(st(1)), 0);
    // squash of retry slot owner
    adv(); do_fetch(1, 32'h3004); mem_ready = 0; expect_req(32'h3000, 1);
    @(negedge clk);
    adv(); squash[1] = 1;
    @(negedge clk);
    chk(cache_blocked_o == 1, "R4 T1 blocked", LW'(cache_blocked_o), 1);
    chk(st(1) == 3'd4, "R4 T1 wait retry", LW'(st(1)), 4);
    adv(); mem_retry = 1;
    @(negedge clk);
    chk(mem_req_valid_o == 0, "R7 empty slot no resend", LW'(mem_req_valid_o), 0);
    chk(cache_blocked_o == 1, "R9 block kept after squash", LW'(cache_blocked_o), 1);
    chk(st(1) == 3'd1, "R9 owner squashed", LW'(st(1)), 1);
    adv();
    @(negedge clk);
    chk(cache_blocked_o == 0, "R7 block cleared", LW'(cache_blocked_o), 0);
    chk(st(1) == 3'd0, "R12 owner back to run", LW'(st(1)), 0);
    chk(exp_q.size() == 0, "R1 all requests seen", LW'(exp_q.size()), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule